// File: doc/BRIEF.md
# Byte I/O Bus Device Port

This block is the device-side end of an 8-bit processor I/O bus. The processor drives three active-low control lines that hold a 3-bit bus state. It also drives eight active-low output data lines. The device answers on eight active-low input data lines. These lines are wired together across all devices and pulled up passively, so a device can only pull a line to ground or release it. The port decodes the bus state and captures the command byte or the data byte when the matching state is present. During the data-input state it pulls the input lines low according to a local reply byte. It also gives the device logic a one-cycle strobe for each new bus operation.

The decoded state is tracked by a state register with eight named states:

| Code | State |
|------|-------|
| 0 | `ST_NONE` |
| 1 | `ST_CTL_OUT` |
| 2 | `ST_DAT_OUT` |
| 3 | `ST_SER_SPACE` |
| 4 | `ST_CONC_ACK` |
| 5 | `ST_INT_ACK` |
| 6 | `ST_DAT_IN` |
| 7 | `ST_SPARE` |

On every clock edge the register moves to whatever state the control lines carry. Any state may follow any state. A transition is an "entry" when the new state differs from the held one and is not `ST_NONE`, and an entry raises that state's strobe. Holding a state, or returning to `ST_NONE`, raises no strobe.

Top module: `byte_io_port`

## Requirements
- R1: While `bus_rst_n` is low, and in the first cycle after it rises, the control byte, data byte and reply byte read 0, `op_strobe` is 0, `bus_state` is 0 and every `rd_pull` bit is 0.
- R2: The state code is the bitwise inverse of `ctl_n`, with `ctl_n[0]` as the least significant bit. After each clock edge `bus_state` shows the code that was present at that edge.
- R3: At each clock edge where the code is 1 (control output), `ctl_byte` takes the inverse of `wr_n`, so a low line stores a 1. Any code other than 1 leaves `ctl_byte` unchanged.
- R4: At each clock edge where the code is 2 (data output), `dat_byte` takes the inverse of `wr_n`. Any code other than 2 leaves `dat_byte` unchanged.
- R5: While the code is 6 (data input), `rd_pull[i]` is 1 exactly where bit i of the reply byte is 1. `rd_lvl` is always 0, the level driven when a pull is enabled.
- R6: While the code is anything other than 6, every `rd_pull` bit is 0, so all input lines are released.
- R7: After an edge that enters a state k from 1 to 7, `op_strobe` is the one-hot value with only bit k set, for exactly one cycle. Holding state k for further cycles gives `op_strobe` = 0. Code 0 never raises a strobe.
- R8: At a clock edge with `rep_we` high, the reply byte is loaded from `rep_data` in any bus state. `rep_byte` shows its value.
- R9: Codes 3, 4, 5 and 7 change neither the control byte nor the data byte, whatever is on `wr_n`. They only raise their strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| bus_rst_n | input | 1 | Master reset, active low, asynchronous |
| ctl_n | input | 3 | Inverted bus-state lines, bit 0 least significant |
| wr_n | input | 8 | Output data lines from the processor, active low |
| rd_pull | output | 8 | Per-line pull enable for the input data lines |
| rd_lvl | output | 8 | Level driven when a pull is enabled (always 0) |
| rep_we | input | 1 | Device-side load strobe for the reply byte |
| rep_data | input | 8 | Device-side reply value |
| rep_byte | output | 8 | Current reply byte |
| ctl_byte | output | 8 | Last captured control byte |
| dat_byte | output | 8 | Last captured data byte |
| bus_state | output | 3 | Registered state code |
| op_strobe | output | 8 | One-hot entry strobe, bit k for state k |

## Verification
The assertions assume that the control and data lines are steady around each rising clock edge. They also assume that `bus_rst_n` is low from time zero until the first edges have passed. The bench meets both assumptions by changing every input on the falling clock edge. It holds reset low for several cycles before the first command. The stimulus holds states for one to three cycles, including back-to-back changes between non-idle codes. It also loads the reply byte while the bus is in the data-input state, so that the pull pattern changes within a single hold.

// File: rtl/byte_io_pkg.sv
package byte_io_pkg;
    localparam int CODE_W = 3;
    localparam int NUM_ST = 1 << CODE_W;

    typedef enum logic [CODE_W-1:0] {
        ST_NONE      = 3'd0,
        ST_CTL_OUT   = 3'd1,
        ST_DAT_OUT   = 3'd2,
        ST_SER_SPACE = 3'd3,
        ST_CONC_ACK  = 3'd4,
        ST_INT_ACK   = 3'd5,
        ST_DAT_IN    = 3'd6,
        ST_SPARE     = 3'd7
    } bus_state_t;
endpackage

// File: rtl/byte_io_decode.sv
module byte_io_decode
    import byte_io_pkg::*;
(
    input  logic [CODE_W-1:0] ctl_n,
    output bus_state_t        cmd
);
    always_comb begin
        cmd = bus_state_t'(~ctl_n);
    end
endmodule

// File: rtl/byte_io_fsm.sv
module byte_io_fsm
    import byte_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_t        cmd,
    output bus_state_t        state_q,
    output logic [NUM_ST-1:0] strobe_q
);
    bus_state_t        state_d;
    logic [NUM_ST-1:0] strobe_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_NONE;
            strobe_q <= '0;
        end else begin
            state_q  <= state_d;
            strobe_q <= strobe_d;
        end
    end

    // next state and entry strobe
    always_comb begin
        state_d  = cmd;
        strobe_d = '0;
        unique case (cmd)
            ST_NONE: strobe_d = '0;
            ST_CTL_OUT, ST_DAT_OUT, ST_SER_SPACE, ST_CONC_ACK,
            ST_INT_ACK, ST_DAT_IN, ST_SPARE: begin
                if (cmd != state_q)
                    strobe_d = NUM_ST'(1) << cmd;
            end
            default: strobe_d = '0;
        endcase
    end
endmodule

// File: rtl/byte_io_regs.sv
module byte_io_regs
    import byte_io_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_t    cmd,
    input  logic [DW-1:0] wr_n,
    input  logic          rep_we,
    input  logic [DW-1:0] rep_data,
    output logic [DW-1:0] ctl_q,
    output logic [DW-1:0] dat_q,
    output logic [DW-1:0] rep_q,
    output logic [DW-1:0] pull,
    output logic [DW-1:0] lvl
);
    logic [DW-1:0] wr_val;
    logic          drive;

    assign wr_val = ~wr_n;
    assign drive  = (cmd == ST_DAT_IN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            dat_q <= '0;
            rep_q <= '0;
        end else begin
            if (cmd == ST_CTL_OUT) ctl_q <= wr_val;
            if (cmd == ST_DAT_OUT) dat_q <= wr_val;
            if (rep_we)            rep_q <= rep_data;
        end
    end

    for (genvar i = 0; i < DW; i++) begin : g_line
        assign pull[i] = drive & rep_q[i];
        assign lvl[i]  = 1'b0;
    end
endmodule

// File: rtl/byte_io_port.sv
module byte_io_port
    import byte_io_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic [CODE_W-1:0] ctl_n,
    input  logic [DW-1:0]     wr_n,
    output logic [DW-1:0]     rd_pull,
    output logic [DW-1:0]     rd_lvl,
    input  logic              rep_we,
    input  logic [DW-1:0]     rep_data,
    output logic [DW-1:0]     rep_byte,
    output logic [DW-1:0]     ctl_byte,
    output logic [DW-1:0]     dat_byte,
    output logic [CODE_W-1:0] bus_state,
    output logic [NUM_ST-1:0] op_strobe
);
    bus_state_t cmd;
    bus_state_t st_q;

    byte_io_decode u_dec (
        .ctl_n (ctl_n),
        .cmd   (cmd)
    );

    byte_io_fsm u_fsm (
        .clk      (clk),
        .rst_n    (bus_rst_n),
        .cmd      (cmd),
        .state_q  (st_q),
        .strobe_q (op_strobe)
    );

    byte_io_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (bus_rst_n),
        .cmd      (cmd),
        .wr_n     (wr_n),
        .rep_we   (rep_we),
        .rep_data (rep_data),
        .ctl_q    (ctl_byte),
        .dat_q    (dat_byte),
        .rep_q    (rep_byte),
        .pull     (rd_pull),
        .lvl      (rd_lvl)
    );

    assign bus_state = st_q;
endmodule

// File: rtl/byte_io_port_chk.sv
module byte_io_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          bus_rst_n,
    input logic [2:0]    ctl_n,
    input logic [DW-1:0] wr_n,
    input logic [DW-1:0] rd_pull,
    input logic [DW-1:0] rep_byte,
    input logic [DW-1:0] ctl_byte,
    input logic [DW-1:0] dat_byte,
    input logic [2:0]    bus_state,
    input logic [7:0]    op_strobe
);
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!bus_rst_n)
        $onehot0(op_strobe)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (|op_strobe) |=> ((op_strobe & $past(op_strobe)) == '0)); // R7
    AST_STATE_FOLLOW: assert property (@(posedge clk) disable iff (!bus_rst_n)
        1'b1 |=> (bus_state == ~$past(ctl_n))); // R2
    AST_RELEASE: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (ctl_n != 3'b001) |-> (rd_pull == '0)); // R6
    AST_PULL_SUBSET: assert property (@(posedge clk) disable iff (!bus_rst_n)
        ((rd_pull & ~rep_byte) == '0)); // R5
    AST_CTL_CAPTURE: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (ctl_n == 3'b110) |=> (ctl_byte == ~$past(wr_n))); // R3
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (ctl_n != 3'b110) |=> $stable(ctl_byte)); // R9
    AST_DAT_HOLD: assert property (@(posedge clk) disable iff (!bus_rst_n)
        (ctl_n != 3'b101) |=> $stable(dat_byte)); // R4
endmodule

bind byte_io_port byte_io_port_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .bus_rst_n (bus_rst_n),
    .ctl_n     (ctl_n),
    .wr_n      (wr_n),
    .rd_pull   (rd_pull),
    .rep_byte  (rep_byte),
    .ctl_byte  (ctl_byte),
    .dat_byte  (dat_byte),
    .bus_state (bus_state),
    .op_strobe (op_strobe)
);

// File: tb/byte_io_port_bench.sv
module byte_io_port_bench;
    logic       clk = 1'b0;
    logic       bus_rst_n = 1'b0;
    logic [2:0] ctl_n = 3'b111;
    logic [7:0] wr_n = 8'hFF;
    logic       rep_we = 1'b0;
    logic [7:0] rep_data = 8'h00;
    logic [7:0] rd_pull, rd_lvl, rep_byte, ctl_byte, dat_byte, op_strobe;
    logic [2:0] bus_state;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    int m_ctl = 0, m_dat = 0, m_rep = 0, m_prev = 0, m_strobe = -1;

    always #4 clk = ~clk;

    byte_io_port u_byte_io_port (
        .clk(clk), .bus_rst_n(bus_rst_n), .ctl_n(ctl_n), .wr_n(wr_n),
        .rd_pull(rd_pull), .rd_lvl(rd_lvl), .rep_we(rep_we), .rep_data(rep_data),
        .rep_byte(rep_byte), .ctl_byte(ctl_byte), .dat_byte(dat_byte),
        .bus_state(bus_state), .op_strobe(op_strobe)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        int exp_strobe;
        exp_strobe = (m_strobe < 0) ? 0 : (1 << m_strobe);
        chk("R3 ctl_byte", int'(ctl_byte), m_ctl);
        chk("R4 dat_byte", int'(dat_byte), m_dat);
        chk("R8 rep_byte", int'(rep_byte), m_rep);
        chk("R2 bus_state", int'(bus_state), m_prev);
        chk("R7 op_strobe", int'(op_strobe), exp_strobe);
    endtask

    // one bus cycle: drive at negedge, check comb, clock, check registers
    task automatic step(int code, int dbyte, bit we, int wdata);
        int pull_exp;
        @(negedge clk);
        ctl_n    = ~3'(code);
        wr_n     = ~8'(dbyte);
        rep_we   = we;
        rep_data = 8'(wdata);
        #1;
        pull_exp = (code == 6) ? m_rep : 0;
        chk((code == 6) ? "R5 rd_pull" : "R6 rd_pull", int'(rd_pull), pull_exp);
        chk("R5 rd_lvl", int'(rd_lvl), 0);
        @(posedge clk);
        if (code == 1) m_ctl = dbyte & 255;
        if (code == 2) m_dat = dbyte & 255;
        if (we) m_rep = wdata & 255;
        m_strobe = (code != m_prev && code != 0) ? code : -1;
        m_prev = code;
        #1;
        chk_regs();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ctl_byte", int'(ctl_byte), 0);
        chk("R1 op_strobe", int'(op_strobe), 0);
        chk("R1 rd_pull", int'(rd_pull), 0);
        @(negedge clk);
        bus_rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_regs();
        chk("R1 rd_pull", int'(rd_pull), 0);

        // R3: control output held two cycles, one strobe
        step(1, 8'hA5, 0, 0);
        step(1, 8'hA5, 0, 0);
        step(0, 8'h00, 0, 0);
        // R4: data output
        step(2, 8'h3C, 0, 0);
        // direct change 2->1 (R7 entry without idle)
        step(1, 8'h81, 0, 0);
        // R8 + R5: reply loaded, then data input, reload during hold
        step(0, 8'h00, 1, 8'h96);
        step(6, 8'hFF, 0, 0);
        step(6, 8'hFF, 1, 8'h0F);
        step(6, 8'hFF, 0, 0);
        // R9: other codes ignore the data lines
        step(3, 8'h11, 0, 0);
        step(4, 8'h22, 0, 0);
        step(5, 8'h33, 0, 0);
        step(7, 8'h44, 0, 0);
        step(7, 8'h55, 0, 0);
        step(0, 8'h66, 0, 0);

        // pseudo-random sweep with holds of 1..3 cycles
        seed = 17;
        for (int i = 0; i < 300; i++) begin
            int code, hold, db;
            seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
            code = (seed >> 8) % 8;
            hold = 1 + ((seed >> 4) % 3);
            db = (seed >> 12) & 255;
            for (int h = 0; h < hold; h++)
                step(code, db ^ h, ((seed >> 20) & 3) == 0, (seed >> 22) & 255);
        end

        // R1: reset mid-operation clears registers
        @(negedge clk);
        ctl_n = ~3'd1;
        bus_rst_n = 1'b0;
        #1;
        chk("R1 ctl_byte", int'(ctl_byte), 0);
        chk("R1 rep_byte", int'(rep_byte), 0);
        chk("R1 bus_state", int'(bus_state), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule